// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Sequencer

This block is the bus-facing engine of a 2K x 8 serial non-volatile memory. It cleans up the SCL and SDA lines against a fast system clock and recognises START and STOP conditions. It shifts bytes in and out most significant bit first and answers each received byte with an acknowledge, or holds back the acknowledge. SDA is open drain: the block only ever asks for the line to be pulled low.

The first byte after a START selects the device and carries the upper three array address bits. A write then supplies a byte address and data bytes. Each accepted data byte goes to an external page latch. A correctly placed STOP tells that latch to program. Reads fetch bytes from a synchronous array port that has one cycle of latency. The read address counter runs on through the whole array. While the external program cycle is running, the block stays completely silent on the bus.

Top module: `twi_mem_slave`

## Requirements
- R1: START is SDA falling while SCL is high. STOP is SDA rising while SCL is high. Data bits are sampled on SCL rising edges, most significant bit first. The block changes its SDA drive only after an SCL falling edge.
- R2: Select byte layout: bits 7..4 must be 1010, bits 3..1 give array address bits 10..8, and bit 0 is R/W (1 = read). On any other code the block answers NACK and ignores the bus until the next START.
- R3: After every byte it accepts, the block pulls SDA low for the 9th clock. After every byte it sends, it releases SDA and samples the master's acknowledge in the 9th clock.
- R4: The write-control input is checked from START until the end of the address byte. If it is high at any time in that window, the select and address bytes are still ACKed, every data byte is NACKed, and no byte is passed to the latch.
- R5: A write targets address {select bits 3..1, address byte}. The address ack pulses `pl_clear`. Each ACKed data byte appears once on `pl_we` with its address and data. After each data byte the low 4 address bits increment and wrap inside the 16-byte page.
- R6: `pl_commit` pulses only for a STOP that arrives during the clock that follows the ACK of a data byte. A STOP anywhere else ends the transfer with no commit.
- R7: While `pl_busy` is high, the block never drives SDA and ignores all bus activity, so a select byte is NACKed.
- R8: Random read: a write select and an address byte, then a repeated START with a read select. The first data byte returned comes from the loaded address.
- R9: After each byte sent, the address counter increments over the full 11 bits, so 0x7FF is followed by 0x000. A master ACK makes the block send the next byte. A master NACK ends the transfer and the block releases the bus.
- R10: Reads behave the same whatever the level of the write-control input.
- R11: A START in the middle of a byte abandons the transfer in progress and starts decoding a new select byte.
- R12: A read select with no address byte first reads from {select bits 3..1, low 8 bits of the current counter}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Bus data line as received |
| sda_oe | output | 1 | 1 pulls SDA low |
| wp_i | input | 1 | Write control, high blocks data writes |
| pl_clear | output | 1 | Pulse: empty the page latch |
| pl_we | output | 1 | Pulse: load one byte into the page latch |
| pl_addr | output | 11 | Array address of the latched byte |
| pl_data | output | 8 | Data of the latched byte |
| pl_commit | output | 1 | Pulse: start programming the latch |
| pl_busy | input | 1 | Program cycle in progress |
| rd_addr | output | 11 | Read address to the array |
| rd_data | input | 8 | Array data, valid one cycle after rd_addr |

## Verification
The bench targets the STOP slot: a STOP placed two bits into a data byte must not program. A design that commits on any STOP would corrupt that location. Write control is raised only during the address byte, which catches a design that samples it at START alone, because that design would ACK and write the data. A sequential read runs across 0x7FF, and a page write runs across its 16-byte boundary. A design that carries into the wrong bits returns or writes the wrong location. A select byte is also sent during the program cycle, and a START is sent mid-byte. A wrong design would ACK the select, drive SDA, or hang on the abandoned byte.

// File: rtl/twi_mem_pkg.sv
`timescale 1ns/1ps
package twi_mem_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SEL, ST_ADDR, ST_WR, ST_RD
  } xfer_state_t;

  localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/twi_deglitch.sv
`timescale 1ns/1ps
module twi_deglitch #(
  parameter int SYNC = 2,
  parameter int VOTE = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [SYNC-1:0] sync_q;
  logic [VOTE-1:0] hist_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      hist_q <= '1;
      dout   <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], din};
      hist_q <= {hist_q[VOTE-2:0], sync_q[SYNC-1]};
      if (&hist_q)       dout <= 1'b1;
      else if (~|hist_q) dout <= 1'b0;
    end
  end
endmodule

// File: rtl/twi_bus_events.sv
`timescale 1ns/1ps
module twi_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign scl_rise = scl & ~scl_q;
  assign scl_fall = ~scl & scl_q;
  assign start_c  = scl & scl_q & sda_q & ~sda;
  assign stop_c   = scl & scl_q & ~sda_q & sda;
endmodule

// File: rtl/twi_mem_slave.sv
`timescale 1ns/1ps
module twi_mem_slave
  import twi_mem_pkg::*;
#(
  parameter int AW        = 11,
  parameter int DW        = 8,
  parameter int PAGE_BITS = 4,
  parameter int SYNC      = 2,
  parameter int VOTE      = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic          wp_i,
  output logic          pl_clear,
  output logic          pl_we,
  output logic [AW-1:0] pl_addr,
  output logic [DW-1:0] pl_data,
  output logic          pl_commit,
  input  logic          pl_busy,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data
);
  localparam int HI_W = AW - DW;
  localparam logic [3:0] BYTE_END = 4'(DW);
  localparam logic [3:0] ACK_END  = 4'(DW + 1);

  // line conditioning, one identical path per bus wire
  logic [1:0] raw, clean;
  assign raw = {scl_i, sda_i};
  for (genvar g = 0; g < 2; g++) begin : g_line
    twi_deglitch #(.SYNC(SYNC), .VOTE(VOTE)) u_flt (
      .clk(clk), .rst(rst), .din(raw[g]), .dout(clean[g]));
  end

  logic scl_rise, scl_fall, start_c, stop_c;
  twi_bus_events u_ev (
    .clk(clk), .rst(rst), .scl(clean[1]), .sda(clean[0]),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_c(start_c), .stop_c(stop_c));

  xfer_state_t     st;
  logic [3:0]      bitn;
  logic [DW-1:0]   shreg;
  logic [DW-2:0]   tx;
  logic [AW-1:0]   addr;
  logic [HI_W-1:0] hi;
  logic            wp_lat, wr_any, mack;

  assign rd_addr = addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; bitn <= '0; shreg <= '0; tx <= '0; addr <= '0; hi <= '0;
      wp_lat <= 1'b0; wr_any <= 1'b0; mack <= 1'b0; sda_oe <= 1'b0;
      pl_clear <= 1'b0; pl_we <= 1'b0; pl_commit <= 1'b0;
      pl_addr <= '0; pl_data <= '0;
    end else begin
      pl_clear  <= 1'b0;
      pl_we     <= 1'b0;
      pl_commit <= 1'b0;
      if (pl_busy) begin
        st <= ST_IDLE; sda_oe <= 1'b0; bitn <= '0;
      end else if (start_c) begin
        st <= ST_SEL; bitn <= '0; sda_oe <= 1'b0;
        wp_lat <= wp_i; wr_any <= 1'b0;
      end else if (stop_c) begin
        if (st == ST_WR && bitn == 4'd1 && wr_any) pl_commit <= 1'b1;
        st <= ST_IDLE; sda_oe <= 1'b0; bitn <= '0;
      end else begin
        if (st == ST_SEL || st == ST_ADDR) wp_lat <= wp_lat | wp_i;
        if (st != ST_IDLE) begin
          if (scl_rise) begin
            if (bitn < BYTE_END) shreg <= {shreg[DW-2:0], clean[0]};
            if (bitn == BYTE_END) mack <= ~clean[0];
            if (bitn != ACK_END) bitn <= bitn + 4'd1;
          end else if (scl_fall) begin
            if (bitn == BYTE_END) begin
              unique case (st)
                ST_SEL: begin
                  if (shreg[DW-1:HI_W+1] == DEV_CODE) begin
                    sda_oe <= 1'b1;
                    hi     <= shreg[HI_W:1];
                    if (shreg[0]) begin
                      st   <= ST_RD;
                      addr <= {shreg[HI_W:1], addr[DW-1:0]};
                    end else begin
                      st <= ST_ADDR;
                    end
                  end else begin
                    st <= ST_IDLE;
                  end
                end
                ST_ADDR: begin
                  sda_oe   <= 1'b1;
                  addr     <= {hi, shreg};
                  pl_clear <= 1'b1;
                  st       <= ST_WR;
                end
                ST_WR: begin
                  if (!wp_lat) begin
                    sda_oe  <= 1'b1;
                    pl_we   <= 1'b1;
                    pl_addr <= addr;
                    pl_data <= shreg;
                    wr_any  <= 1'b1;
                    addr[PAGE_BITS-1:0] <= addr[PAGE_BITS-1:0] + 1'b1;
                  end
                end
                ST_RD: begin
                  sda_oe <= 1'b0;
                  addr   <= addr + 1'b1;
                end
                default: ;
              endcase
            end else if (bitn == ACK_END) begin
              bitn <= '0;
              if (st == ST_RD) begin
                if (mack) begin
                  tx     <= rd_data[DW-2:0];
                  sda_oe <= ~rd_data[DW-1];
                end else begin
                  st     <= ST_IDLE;
                  sda_oe <= 1'b0;
                end
              end else begin
                sda_oe <= 1'b0;
              end
            end else if (st == ST_RD && bitn != 4'd0) begin
              sda_oe <= ~tx[DW-2];
              tx     <= {tx[DW-3:0], 1'b1};
            end
          end
        end
      end
    end
  end

  // R7
  busy_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    pl_busy && $past(pl_busy) |-> !sda_oe);
  // R6
  commit_slot_chk: assert property (@(posedge clk) disable iff (rst)
    pl_commit |-> $past(stop_c));
  // R1
  oe_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> $past(scl_fall));
  // R3
  we_acked_chk: assert property (@(posedge clk) disable iff (rst)
    pl_we |-> sda_oe);
  // R5
  latch_ops_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pl_we, pl_commit, pl_clear}));
endmodule

// File: tb/twi_mem_slave_test.sv
`timescale 1ns/1ps
module twi_mem_slave_test;
  localparam int Q    = 12;
  localparam int PROG = 2000;
  localparam int WD   = 190000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1, m_oe = 1'b0, wp = 1'b0;
  logic sda_oe, pl_clear, pl_we, pl_commit, pl_busy;
  logic [10:0] pl_addr, rd_addr;
  logic [7:0]  pl_data, rd_data;
  wire sda_bus = ~(sda_oe | m_oe);

  always #2.5 clk = ~clk;

  twi_mem_slave uut (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .wp_i(wp), .pl_clear(pl_clear), .pl_we(pl_we), .pl_addr(pl_addr),
    .pl_data(pl_data), .pl_commit(pl_commit), .pl_busy(pl_busy),
    .rd_addr(rd_addr), .rd_data(rd_data));

  int tests = 0, fails = 0;
  int n_commit = 0;
  int busy_cnt = 0;
  logic [7:0]  mem [0:2047];
  logic [10:0] qa[$];
  logic [7:0]  qd[$];

  assign pl_busy = (busy_cnt != 0);

  // behavioural page latch, program timer and array
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 2048; i++) mem[i] = 8'hFF;
      qa.delete(); qd.delete();
      busy_cnt <= 0;
    end else begin
      rd_data <= mem[rd_addr];
      if (pl_clear) begin qa.delete(); qd.delete(); end
      if (pl_we) begin qa.push_back(pl_addr); qd.push_back(pl_data); end
      if (pl_commit) begin
        busy_cnt <= PROG;
        n_commit++;
      end else if (busy_cnt > 0) begin
        if (busy_cnt == 1)
          foreach (qa[i]) mem[qa[i]] = qd[i];
        busy_cnt <= busy_cnt - 1;
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // R7: compared on every clock of the program cycle
  always @(negedge clk)
    if (!rst && pl_busy) chk("R7", "sda driven while busy", sda_oe, 0);

  task automatic qwait; repeat (Q) @(negedge clk); endtask
  task automatic m_start;
    m_oe = 1'b0; qwait; m_scl = 1'b1; qwait; m_oe = 1'b1; qwait; m_scl = 1'b0; qwait;
  endtask
  task automatic m_stop;
    m_oe = 1'b1; qwait; m_scl = 1'b1; qwait; m_oe = 1'b0; qwait;
  endtask
  task automatic m_bit(input logic b);
    m_oe = ~b; qwait; m_scl = 1'b1; qwait; qwait; m_scl = 1'b0; qwait;
  endtask
  task automatic m_rbit(output logic b);
    m_oe = 1'b0; qwait; m_scl = 1'b1; qwait; b = sda_bus; qwait; m_scl = 1'b0; qwait;
  endtask
  task automatic send(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) m_bit(d[i]);
    m_rbit(b);
    ack = ~b;
  endtask
  task automatic recv(input logic give_ack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin m_rbit(b); d[i] = b; end
    m_bit(~give_ack);
  endtask
  task automatic wait_prog;
    repeat (30) @(negedge clk);
    while (pl_busy) @(negedge clk);
    repeat (10) @(negedge clk);
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] d;
    int c0;
    repeat (6) @(negedge clk);
    rst = 1'b0;
    repeat (6) @(negedge clk);
    chk("R1", "reset sda_oe", sda_oe, 0);
    chk("R5", "reset pl_we", pl_we, 0);
    chk("R6", "reset pl_commit", pl_commit, 0);

    // byte write to 0x235, then poll while programming
    m_start;
    send(8'hA4, a); chk("R2", "write select ack", a, 1);
    send(8'h35, a); chk("R3", "address ack", a, 1);
    send(8'h5A, a); chk("R3", "data ack", a, 1);
    m_stop;
    chk("R6", "byte write commits", n_commit, 1);
    m_start;
    send(8'hA4, a); chk("R7", "select during program NACK", a, 0);
    m_stop;
    wait_prog;
    chk("R5", "mem[235]", mem[11'h235], 8'h5A);

    // random read of 0x235
    m_start; send(8'hA4, a); send(8'h35, a);
    m_start; send(8'hA5, a); chk("R8", "read select ack", a, 1);
    recv(1'b0, d); m_stop;
    chk("R8", "random read data", d, 8'h5A);

    // page write crossing the 16-byte boundary
    m_start; send(8'hA0, a); send(8'h1E, a);
    send(8'h11, a); send(8'h22, a); send(8'h33, a); send(8'h44, a);
    m_stop; wait_prog;
    chk("R5", "page mem[01E]", mem[11'h01E], 8'h11);
    chk("R5", "page mem[01F]", mem[11'h01F], 8'h22);
    chk("R5", "page wrap mem[010]", mem[11'h010], 8'h33);
    chk("R5", "page wrap mem[011]", mem[11'h011], 8'h44);
    chk("R5", "no carry mem[020]", mem[11'h020], 8'hFF);

    // write control high for the whole transfer
    c0 = n_commit; wp = 1'b1;
    m_start;
    send(8'hA0, a); chk("R4", "select ack with wp", a, 1);
    send(8'h40, a); chk("R4", "address ack with wp", a, 1);
    send(8'h99, a); chk("R4", "data NACK with wp", a, 0);
    m_stop; wp = 1'b0; wait_prog;
    chk("R4", "no commit with wp", n_commit, c0);
    chk("R4", "mem[040] kept", mem[11'h040], 8'hFF);

    // write control high only during the address byte
    m_start; send(8'hA0, a);
    wp = 1'b1; send(8'h41, a); wp = 1'b0;
    send(8'h98, a); chk("R4", "data NACK after wp in address", a, 0);
    m_stop; wait_prog;
    chk("R4", "no commit after wp in address", n_commit, c0);
    chk("R4", "mem[041] kept", mem[11'h041], 8'hFF);

    // wrong device code
    m_start;
    send(8'hB0, a); chk("R2", "foreign select NACK", a, 0);
    send(8'h00, a); chk("R2", "ignored until START", a, 0);
    m_stop; wait_prog;
    chk("R2", "no commit after foreign select", n_commit, c0);

    // STOP outside the slot after the data ack
    m_start; send(8'hA0, a); send(8'h50, a);
    send(8'h77, a); chk("R3", "data ack before late stop", a, 1);
    m_bit(1'b1); m_bit(1'b0); m_stop; wait_prog;
    chk("R6", "late stop no commit", n_commit, c0);
    chk("R6", "mem[050] kept", mem[11'h050], 8'hFF);

    // fill 0x7FF and 0x000..0x002 for the wrap test
    m_start; send(8'hAE, a); send(8'hFF, a); send(8'hC3, a); m_stop; wait_prog;
    m_start; send(8'hA0, a); send(8'h00, a);
    send(8'h3C, a); send(8'h81, a); send(8'h6D, a); m_stop; wait_prog;
    chk("R6", "commit count", n_commit, c0 + 2);

    // sequential read across the top of the array
    m_start; send(8'hAE, a); send(8'hFE, a);
    m_start; send(8'hAF, a);
    recv(1'b1, d); chk("R9", "seq 7FE", d, 8'hFF);
    recv(1'b1, d); chk("R9", "seq 7FF", d, 8'hC3);
    recv(1'b1, d); chk("R9", "seq wrap 000", d, 8'h3C);
    recv(1'b0, d); chk("R9", "seq 001", d, 8'h81);
    chk("R9", "bus released after NACK", sda_oe, 0);
    m_stop;

    // current-address read continues from the counter
    m_start; send(8'hA1, a); chk("R12", "current select ack", a, 1);
    recv(1'b0, d); m_stop;
    chk("R12", "current read 002", d, 8'h6D);

    // read with write control high
    wp = 1'b1;
    m_start; send(8'hA4, a); send(8'h35, a);
    m_start; send(8'hA5, a); recv(1'b0, d); m_stop;
    wp = 1'b0;
    chk("R10", "read with wp", d, 8'h5A);

    // START in the middle of a data byte
    c0 = n_commit;
    m_start; send(8'hA0, a); send(8'h10, a);
    m_bit(1'b1); m_bit(1'b0); m_bit(1'b1);
    m_start; send(8'hA1, a); chk("R11", "select after mid-byte START", a, 1);
    recv(1'b0, d); m_stop; wait_prog;
    chk("R11", "read after abort", d, 8'h33);
    chk("R11", "no commit after abort", n_commit, c0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule